// File: doc/BRIEF.md
# Four-Mode Power Mode Sequencer

This block chooses the operating mode of a device. There are four modes: Active, Power Save, Idle and Halt. Software moves the device to a lower-power mode by setting bits in a 4-bit control register. The two deepest modes also need the CPU to signal that it is waiting for an interrupt. Hardware wake events bring the device back to Active. These are either maskable wake lines or a non-maskable interrupt.

For each mode the block drives four enables. The first switches the high-frequency oscillator on or off. The second selects the main clock or the slow clock as the system clock. The third gates the general module clock. The fourth gates the clock of the timer/watchdog. Wake events are held in a latch that stays set until the interrupt controller acknowledges it. On leaving Halt the block restarts the oscillator and keeps every clock gated until the oscillator reports that it is stable.

Top module: `pwr_mode_seq`

## Requirements
- R1: Reset is synchronous and active-low. It puts the block in Active, clears the control register and the wake latch, and makes `cur_mode` read 00. The `cur_mode` codes are 00 Active, 01 Power Save, 10 Idle and 11 Halt (also used while the oscillator warms up).
- R2: Active drives these outputs: `hfo_en`=1, `sys_clk_slow`=0, `mod_clk_en`=1 and `twm_clk_en`=1.
- R3: The control register bits are: bit0 power-save request, bit1 idle request, bit2 halt request, bit3 keep-oscillator. With bit0 at 1, Active moves to Power Save two cycles after the write. Clearing bit0 returns the block to Active. Power Save drives `sys_clk_slow`=1, `mod_clk_en`=1 and `twm_clk_en`=1, and sets `hfo_en` equal to bit3.
- R4: The block enters Idle only from Active or Power Save, only while bit1 is set, and only in a cycle where `cpu_wait` is high. Bit1 alone changes nothing. Idle drives `mod_clk_en`=0, `twm_clk_en`=1 and `sys_clk_slow`=1, and sets `hfo_en` equal to bit3.
- R5: The block enters Halt when bit2 is set and `cpu_wait` is high. Halt drives `hfo_en`, `mod_clk_en` and `twm_clk_en` to 0.
- R6: If bit1 and bit2 are both set when `cpu_wait` is high, the block enters Halt.
- R7: The wake latch sets one cycle after an event. An event is any `wake_in` line whose `wake_mask` bit is 1, or `nmi`. A line whose mask bit is 0 is ignored. Once set, the latch holds until `int_ack`. If a new event arrives in the same cycle as `int_ack`, the latch stays set.
- R8: While the wake latch is set, Power Save or Idle returns to Active on the next clock.
- R9: While the wake latch is set, Halt moves to a warm-up phase. Warm-up drives `hfo_en`=1, keeps `cur_mode`=11 and keeps both clock enables at 0. It lasts until the cycle after `hfo_ready` is seen high, and then the block is in Active.
- R10: Whenever the block returns to Active, bits 0 to 2 of the control register clear on the same edge and bit3 is kept. A register write on that same edge takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock that keeps running in every mode |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr_en | input | 1 | Write strobe for the control register |
| ctl_wr_data | input | 4 | Value written to the control register |
| ctl_rd_data | output | 4 | Current value of the control register |
| cpu_wait | input | 1 | CPU is waiting for an interrupt |
| wake_in | input | N_WAKE | Maskable wake event lines |
| wake_mask | input | N_WAKE | Per-line wake enable |
| nmi | input | 1 | Non-maskable wake event |
| int_ack | input | 1 | Interrupt-acknowledge, clears the wake latch |
| hfo_ready | input | 1 | High-frequency oscillator is stable |
| hfo_en | output | 1 | High-frequency oscillator enable |
| sys_clk_slow | output | 1 | 1 selects the slow clock as the system clock |
| mod_clk_en | output | 1 | General module clock gate enable |
| twm_clk_en | output | 1 | Timer/watchdog clock gate enable |
| cur_mode | output | 2 | Current mode code |
| wake_pending | output | 1 | Wake latch state |

## Verification
The assertions take for granted that all inputs are synchronous to `clk` and held stable across each edge. They also assume that `hfo_ready` says nothing about state outside the warm-up phase. The stimulus changes inputs only on falling edges and pulses `cpu_wait`, the wake lines and `int_ack` for single cycles. It never writes the control register on the edge where a return to Active clears it. Each scenario starts only after the previous wake has been acknowledged, so a stale latched event cannot bounce the block out of a newly entered mode.

// File: rtl/pmc_pkg.sv
// Shared types for the power mode sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package pmc_pkg;
    localparam int CTL_W    = 4;
    localparam int B_PSAVE  = 0;
    localparam int B_IDLE   = 1;
    localparam int B_HALT   = 2;
    localparam int B_HFKEEP = 3;

    typedef enum logic [2:0] {
        ST_ACT = 3'd0,
        ST_PSV = 3'd1,
        ST_IDL = 3'd2,
        ST_HLT = 3'd3,
        ST_WRM = 3'd4
    } pmc_state_e;

    typedef struct packed {
        logic hfo_en;
        logic slow_sel;
        logic mod_en;
        logic twm_en;
    } clk_ctl_t;
endpackage

// File: rtl/pmc_wake_latch.sv
// Collects masked wake lines and NMI into one sticky pending flag.
// Assumes: inputs synchronous to clk; a new event beats a same-cycle acknowledge.
module pmc_wake_latch #(
    parameter int N_WAKE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_WAKE-1:0] wake_in,
    input  logic [N_WAKE-1:0] wake_mask,
    input  logic              nmi,
    input  logic              int_ack,
    output logic              pend_q
);
    logic [N_WAKE-1:0] gated;
    logic              event_now;

    // Per-line enable gating.
    for (genvar g = 0; g < N_WAKE; g++) begin : g_gate
        assign gated[g] = wake_in[g] & wake_mask[g];
    end

    // Any enabled line or NMI counts as an event.
    assign event_now = (|gated) | nmi;

    // Sticky latch: set on event, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= 1'b0;
        else if (event_now) pend_q <= 1'b1;
        else if (int_ack)   pend_q <= 1'b0;
    end

    p_latch_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi || |(wake_in & wake_mask)) |=> pend_q);
    p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !int_ack) |=> pend_q);
endmodule

// File: rtl/pmc_ctl_reg.sv
// Software control register with hardware self-clear of the request bits.
// Assumes: a write and a self-clear on the same edge resolve to the write.
module pmc_ctl_reg
    import pmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             clr_req,
    output logic [CTL_W-1:0] ctl_q
);
    // Register update: write first, then self-clear of request bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctl_q <= '0;
        else if (wr_en)   ctl_q <= wr_data;
        else if (clr_req) ctl_q <= ctl_q & (CTL_W'(1) << B_HFKEEP);
    end

    p_self_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !wr_en) |=> (ctl_q[B_HALT:B_PSAVE] == 3'b000));
endmodule

// File: rtl/pmc_mode_fsm.sv
// Mode sequencer: register/wait driven entry, wake driven exit, warm-up after Halt.
// Assumes: hfo_ready is meaningful only while in the warm-up state.
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTL_W-1:0] ctl_q,
    input  logic             cpu_wait,
    input  logic             pend,
    input  logic             hfo_ready,
    output pmc_state_e       st_q,
    output logic             clr_req
);
    pmc_state_e st_d;
    logic       go_halt, go_idle;

    // Deep-mode requests; halt wins over idle.
    assign go_halt = cpu_wait & ctl_q[B_HALT];
    assign go_idle = cpu_wait & ctl_q[B_IDLE] & ~ctl_q[B_HALT];

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ACT: begin
                if (go_halt)              st_d = ST_HLT;
                else if (go_idle)         st_d = ST_IDL;
                else if (ctl_q[B_PSAVE])  st_d = ST_PSV;
            end
            ST_PSV: begin
                if (pend)                 st_d = ST_ACT;
                else if (go_halt)         st_d = ST_HLT;
                else if (go_idle)         st_d = ST_IDL;
                else if (!ctl_q[B_PSAVE]) st_d = ST_ACT;
            end
            ST_IDL: if (pend)      st_d = ST_ACT;
            ST_HLT: if (pend)      st_d = ST_WRM;
            ST_WRM: if (hfo_ready) st_d = ST_ACT;
            default:               st_d = ST_ACT;
        endcase
    end

    // Request bits clear on every return to Active.
    assign clr_req = (st_d == ST_ACT) && (st_q != ST_ACT);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_ACT;
        else        st_q <= st_d;
    end

    p_no_deep_without_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_ACT || st_q == ST_PSV) && !cpu_wait) |=> (st_q != ST_IDL && st_q != ST_HLT));
    p_halt_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ACT && cpu_wait && ctl_q[B_HALT]) |=> (st_q == ST_HLT));
    p_idle_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDL && pend) |=> (st_q == ST_ACT));
    p_warm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WRM && !hfo_ready) |=> (st_q == ST_WRM));
endmodule

// File: rtl/pmc_clk_dec.sv
// Maps the sequencer state to oscillator/clock enables and the visible mode code.
// Assumes: the warm-up state is reported as Halt.
module pmc_clk_dec
    import pmc_pkg::*;
(
    input  pmc_state_e st,
    input  logic       hf_keep,
    output clk_ctl_t   cc,
    output logic [1:0] mode
);
    // Per-state enable table.
    always_comb begin
        unique case (st)
            ST_ACT:  cc = '{hfo_en: 1'b1,    slow_sel: 1'b0, mod_en: 1'b1, twm_en: 1'b1};
            ST_PSV:  cc = '{hfo_en: hf_keep, slow_sel: 1'b1, mod_en: 1'b1, twm_en: 1'b1};
            ST_IDL:  cc = '{hfo_en: hf_keep, slow_sel: 1'b1, mod_en: 1'b0, twm_en: 1'b1};
            ST_WRM:  cc = '{hfo_en: 1'b1,    slow_sel: 1'b1, mod_en: 1'b0, twm_en: 1'b0};
            default: cc = '{hfo_en: 1'b0,    slow_sel: 1'b1, mod_en: 1'b0, twm_en: 1'b0};
        endcase
    end

    // Visible mode code; warm-up reads as Halt.
    always_comb begin
        unique case (st)
            ST_ACT:  mode = 2'b00;
            ST_PSV:  mode = 2'b01;
            ST_IDL:  mode = 2'b10;
            default: mode = 2'b11;
        endcase
    end
endmodule

// File: rtl/pwr_mode_seq.sv
// Top of the power mode sequencer: control register, wake latch, FSM, clock decode.
// Assumes: all inputs synchronous to the always-running slow clock clk.
module pwr_mode_seq
    import pmc_pkg::*;
#(
    parameter int N_WAKE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_en,
    input  logic [3:0]        ctl_wr_data,
    output logic [3:0]        ctl_rd_data,
    input  logic              cpu_wait,
    input  logic [N_WAKE-1:0] wake_in,
    input  logic [N_WAKE-1:0] wake_mask,
    input  logic              nmi,
    input  logic              int_ack,
    input  logic              hfo_ready,
    output logic              hfo_en,
    output logic              sys_clk_slow,
    output logic              mod_clk_en,
    output logic              twm_clk_en,
    output logic [1:0]        cur_mode,
    output logic              wake_pending
);
    logic [CTL_W-1:0] ctl_q;
    logic             clr_req;
    pmc_state_e       st_q;
    clk_ctl_t         cc;

    pmc_ctl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr_en), .wr_data(ctl_wr_data),
        .clr_req(clr_req), .ctl_q(ctl_q)
    );

    pmc_wake_latch #(.N_WAKE(N_WAKE)) u_wake (
        .clk(clk), .rst_n(rst_n), .wake_in(wake_in), .wake_mask(wake_mask),
        .nmi(nmi), .int_ack(int_ack), .pend_q(wake_pending)
    );

    pmc_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .cpu_wait(cpu_wait),
        .pend(wake_pending), .hfo_ready(hfo_ready), .st_q(st_q), .clr_req(clr_req)
    );

    pmc_clk_dec u_dec (
        .st(st_q), .hf_keep(ctl_q[B_HFKEEP]), .cc(cc), .mode(cur_mode)
    );

    assign ctl_rd_data  = ctl_q;
    assign hfo_en       = cc.hfo_en;
    assign sys_clk_slow = cc.slow_sel;
    assign mod_clk_en   = cc.mod_en;
    assign twm_clk_en   = cc.twm_en;

    p_main_clk_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_clk_slow |-> (cur_mode == 2'b00 && hfo_en && mod_clk_en && twm_clk_en));
    p_halt_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 2'b11) |-> (!mod_clk_en && !twm_clk_en));
endmodule

// File: tb/test_pwr_mode_seq.sv
// Bench: behavioural reference model compared with the design on every clock,
// plus directed checks per requirement.
module test_pwr_mode_seq;
    localparam int NW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr_en = 1'b0;
    logic [3:0]    ctl_wr_data = '0;
    logic [3:0]    ctl_rd_data;
    logic          cpu_wait = 1'b0;
    logic [NW-1:0] wake_in = '0;
    logic [NW-1:0] wake_mask = '0;
    logic          nmi = 1'b0;
    logic          int_ack = 1'b0;
    logic          hfo_ready = 1'b1;
    logic          hfo_en, sys_clk_slow, mod_clk_en, twm_clk_en, wake_pending;
    logic [1:0]    cur_mode;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    pwr_mode_seq #(.N_WAKE(NW)) i_pwr_mode_seq (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .ctl_rd_data(ctl_rd_data), .cpu_wait(cpu_wait), .wake_in(wake_in),
        .wake_mask(wake_mask), .nmi(nmi), .int_ack(int_ack), .hfo_ready(hfo_ready),
        .hfo_en(hfo_en), .sys_clk_slow(sys_clk_slow), .mod_clk_en(mod_clk_en),
        .twm_clk_en(twm_clk_en), .cur_mode(cur_mode), .wake_pending(wake_pending)
    );

    // Reference model: mode 0 Active, 1 Power Save, 2 Idle, 3 Halt, 4 warm-up.
    int       m_st = 0;
    int       m_nx;
    logic [3:0] m_ctl = '0;
    logic     m_pend = 1'b0;
    logic     m_ev;
    bit       m_ok = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_ctl = '0; m_pend = 1'b0; m_ok = 1'b1;
        end else if (m_ok) begin
            m_ev = (|(wake_in & wake_mask)) || nmi;
            m_nx = m_st;
            if (m_st == 0) begin
                if (cpu_wait && m_ctl[2])      m_nx = 3;
                else if (cpu_wait && m_ctl[1]) m_nx = 2;
                else if (m_ctl[0])             m_nx = 1;
            end else if (m_st == 1) begin
                if (m_pend)                    m_nx = 0;
                else if (cpu_wait && m_ctl[2]) m_nx = 3;
                else if (cpu_wait && m_ctl[1]) m_nx = 2;
                else if (!m_ctl[0])            m_nx = 0;
            end else if (m_st == 2) begin
                if (m_pend) m_nx = 0;
            end else if (m_st == 3) begin
                if (m_pend) m_nx = 4;
            end else begin
                if (hfo_ready) m_nx = 0;
            end
            if (ctl_wr_en)                   m_ctl = ctl_wr_data;
            else if (m_nx == 0 && m_st != 0) m_ctl[2:0] = 3'b000;
            if (m_ev)         m_pend = 1'b1;
            else if (int_ack) m_pend = 1'b0;
            m_st = m_nx;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (m_ok && !done) begin
            int e_hfo, e_slow, e_mod, e_twm, e_mode;
            case (m_st)
                0:       begin e_hfo = 1;        e_slow = 0; e_mod = 1; e_twm = 1; e_mode = 0; end
                1:       begin e_hfo = m_ctl[3]; e_slow = 1; e_mod = 1; e_twm = 1; e_mode = 1; end
                2:       begin e_hfo = m_ctl[3]; e_slow = 1; e_mod = 0; e_twm = 1; e_mode = 2; end
                3:       begin e_hfo = 0;        e_slow = 1; e_mod = 0; e_twm = 0; e_mode = 3; end
                default: begin e_hfo = 1;        e_slow = 1; e_mod = 0; e_twm = 0; e_mode = 3; end
            endcase
            chk(tag, "cur_mode", cur_mode, e_mode);
            chk(tag, "hfo_en", hfo_en, e_hfo);
            chk(tag, "sys_clk_slow", sys_clk_slow, e_slow);
            chk(tag, "mod_clk_en", mod_clk_en, e_mod);
            chk(tag, "twm_clk_en", twm_clk_en, e_twm);
            chk(tag, "ctl_rd_data", ctl_rd_data, m_ctl);
            chk(tag, "wake_pending", wake_pending, m_pend);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [3:0] v);
        ctl_wr_en = 1'b1; ctl_wr_data = v;
        step(1);
        ctl_wr_en = 1'b0;
    endtask

    task automatic pulse_wait();
        cpu_wait = 1'b1; step(1); cpu_wait = 1'b0;
    endtask

    task automatic ack();
        int_ack = 1'b1; step(1); int_ack = 1'b0;
    endtask

    initial begin
        step(3);
        tag = "R1";
        chk("R1", "reset mode", cur_mode, 0);
        chk("R1", "reset ctl", ctl_rd_data, 0);
        chk("R1", "reset pending", wake_pending, 0);
        rst_n = 1'b1;
        step(3);
        tag = "R2";
        chk("R2", "active hfo_en", hfo_en, 1);
        chk("R2", "active slow", sys_clk_slow, 0);

        // R3: power save with oscillator off, then cleared by software.
        tag = "R3";
        wr(4'b0001); step(1);
        chk("R3", "psave mode", cur_mode, 1);
        chk("R3", "psave hfo off", hfo_en, 0);
        chk("R3", "psave module clock", mod_clk_en, 1);
        wr(4'b0000); step(1);
        chk("R3", "psave cleared mode", cur_mode, 0);
        wr(4'b1001); step(2);
        chk("R3", "psave keep hfo", hfo_en, 1);
        wr(4'b1000); step(2);

        // R4: idle bit without wait does nothing; with wait enters Idle.
        tag = "R4";
        wr(4'b1010); step(3);
        chk("R4", "idle bit alone", cur_mode, 0);
        pulse_wait();
        chk("R4", "idle mode", cur_mode, 2);
        chk("R4", "idle module gated", mod_clk_en, 0);
        chk("R4", "idle twm running", twm_clk_en, 1);
        chk("R4", "idle hfo keep", hfo_en, 1);

        // R7: masked-off line ignored, enabled line latched.
        tag = "R7";
        wake_mask = 8'h0F;
        wake_in = 8'h80; step(1); wake_in = '0; step(2);
        chk("R7", "masked line ignored", wake_pending, 0);
        chk("R7", "still idle", cur_mode, 2);
        tag = "R8";
        wake_in = 8'h04; step(1); wake_in = '0;
        chk("R7", "latch set", wake_pending, 1);
        step(1);
        chk("R8", "idle wake to active", cur_mode, 0);
        chk("R10", "idle bit cleared", ctl_rd_data, 4'b1000);
        step(2);
        chk("R7", "latch holds", wake_pending, 1);
        tag = "R7";
        nmi = 1'b1; int_ack = 1'b1; step(1); nmi = 1'b0; int_ack = 1'b0;
        chk("R7", "event beats ack", wake_pending, 1);
        ack();
        chk("R7", "ack clears", wake_pending, 0);

        // R6 / R5: both deep bits, halt wins.
        tag = "R6";
        wr(4'b0110); step(1);
        pulse_wait();
        chk("R6", "halt priority", cur_mode, 3);
        tag = "R5";
        chk("R5", "halt hfo off", hfo_en, 0);
        chk("R5", "halt twm gated", twm_clk_en, 0);
        step(3);

        // R9: NMI wakes Halt; warm-up until oscillator ready.
        tag = "R9";
        hfo_ready = 1'b0;
        nmi = 1'b1; step(1); nmi = 1'b0;
        step(1);
        chk("R9", "warm mode", cur_mode, 3);
        chk("R9", "warm hfo on", hfo_en, 1);
        chk("R9", "warm module gated", mod_clk_en, 0);
        step(4);
        chk("R9", "warm held", cur_mode, 3);
        hfo_ready = 1'b1; step(1);
        chk("R9", "active after ready", cur_mode, 0);
        tag = "R10";
        chk("R10", "deep bits cleared", ctl_rd_data, 4'b0000);
        ack(); step(1);

        // R8 / R10: wake exits Power Save and clears power-save bit.
        tag = "R8";
        wr(4'b0001); step(2);
        chk("R8", "in psave", cur_mode, 1);
        wake_in = 8'h01; step(1); wake_in = '0;
        step(1);
        chk("R8", "psave wake exit", cur_mode, 0);
        chk("R10", "psave bit cleared", ctl_rd_data, 4'b0000);
        step(2);
        chk("R8", "stays active", cur_mode, 0);
        ack();

        // R4 from Power Save: idle+wait enters Idle, then wake by NMI.
        tag = "R4";
        wr(4'b0011); step(2);
        pulse_wait();
        chk("R4", "psave to idle", cur_mode, 2);
        chk("R4", "idle hfo off", hfo_en, 0);
        nmi = 1'b1; step(1); nmi = 1'b0; step(1);
        chk("R8", "nmi idle exit", cur_mode, 0);
        ack(); step(3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule